// File: doc/BRIEF.md
# UART Receive Flow-Control Hysteresis Controller

This block drives the active-low request-to-send line of a UART receiver from the fill level of a 64-entry receive FIFO. Two 4-bit threshold codes set a hysteresis band. Each code is multiplied by four to give a byte count. When occupancy climbs to the upper (halt) level, the block raises `rts_n` so the remote transmitter pauses. It lowers `rts_n` again only after occupancy has drained to the lower (restore) level. Between the two levels the line keeps its last state, so it does not chatter around a single limit.

Software programs the two thresholds through a small byte-wide register port. A second register holds a manual RTS request bit and a receive-interrupt trigger code. When automatic flow control is off, the manual bit drives `rts_n` directly. The block reports two conditions. The first is a threshold pair that cannot form a band; in that case RTS is kept asserted so that data keeps flowing. The second is a halt level below the interrupt trigger level, which would let reception stall in interrupt-driven mode.

Top module: `rx_rts_hysteresis`

## Requirements
- R1: After reset, register 0 reads 0x0F, register 1 reads 0x00, `rts_n` is 1, `cfg_error` is 0 while `auto_en` is 0, and `trig_warn` is 0.
- R2: Register 0 holds the halt code in bits 3:0 and the restore code in bits 7:4. Register 1 holds the manual RTS request in bit 0 and the interrupt trigger code in bits 7:4, and its bits 3:1 read as 0. A write with `wr_en` high takes effect at the clock edge, and `rd_data` shows the register chosen by `addr` combinationally.
- R3: With `auto_en` high and no configuration error, an occupancy at or above 4 × halt code sets `rts_n` to 1 at the next clock edge.
- R4: With `auto_en` high and no configuration error, an occupancy at or below 4 × restore code sets `rts_n` to 0 at the next clock edge.
- R5: With `auto_en` high and no configuration error, an occupancy strictly between the two levels leaves the hysteresis state, and so `rts_n`, unchanged at the next edge.
- R6: `cfg_error` is high exactly when `auto_en` is high and the halt code is less than or equal to the restore code.
- R7: While `cfg_error` is high, `rts_n` is driven to 0 at each clock edge and the hysteresis state is cleared.
- R8: With `auto_en` low, `rts_n` at each edge takes the inverse of the manual request bit, and the hysteresis state is cleared. After re-enabling with occupancy inside the band, `rts_n` is 0.
- R9: `trig_warn` is high exactly when the halt code is less than the interrupt trigger code.
- R10: Occupancy values 61 to 64 are treated as at or above any halt level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic flow control |
| fifo_level | input | 7 | Receive FIFO occupancy, 0 to 64 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select (0: thresholds, 1: control) |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| rts_n | output | 1 | Active-low request to send |
| cfg_error | output | 1 | Threshold pair is invalid while auto mode is on |
| trig_warn | output | 1 | Halt level is below the interrupt trigger level |

## Verification
A directed sweep fills the FIFO from 0 to 64 and then drains it back to 0 with a valid band. This separates the rising edge at the halt level, the hold inside the band and the falling edge at the restore level, so a single-threshold or off-by-one design shows up. Further directed steps use an equal threshold pair, manual mode and re-entry into auto mode inside the band, which tell the fail-safe path apart from the hysteresis path. A long seeded random walk of occupancy, mixed with occasional register rewrites and toggling of `auto_en`, then compares every cycle against a bench model. This catches errors in which thresholds a decision uses and in when it takes effect.

// File: rtl/rx_rts_hysteresis.sv
module rx_rts_hysteresis #(
  parameter int LVL_W  = 7,
  parameter int CODE_W = 4,
  parameter int SCALE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             rts_n,
  output logic             cfg_error,
  output logic             trig_warn
);
  localparam int PAD = LVL_W - CODE_W - SCALE;

  logic [CODE_W-1:0] halt_code, resume_code, trig_code;
  logic              sw_req;
  logic              halted;
  logic [LVL_W-1:0]  halt_lvl, resume_lvl;
  logic              at_halt, at_resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_code   <= '1;
      resume_code <= '0;
      trig_code   <= '0;
      sw_req      <= 1'b0;
    end else if (wr_en) begin
      if (addr) begin
        sw_req    <= wr_data[0];
        trig_code <= wr_data[7:4];
      end else begin
        halt_code   <= wr_data[3:0];
        resume_code <= wr_data[7:4];
      end
    end
  end

  assign rd_data = addr ? {trig_code, 3'b000, sw_req} : {resume_code, halt_code};

  assign halt_lvl   = {{PAD{1'b0}}, halt_code, {SCALE{1'b0}}};
  assign resume_lvl = {{PAD{1'b0}}, resume_code, {SCALE{1'b0}}};
  assign at_halt    = fifo_level >= halt_lvl;
  assign at_resume  = fifo_level <= resume_lvl;

  assign cfg_error = auto_en && (halt_code <= resume_code);
  assign trig_warn = halt_code < trig_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      rts_n  <= 1'b1;
    end else if (!auto_en) begin
      halted <= 1'b0;
      rts_n  <= !sw_req;
    end else if (cfg_error) begin
      halted <= 1'b0;
      rts_n  <= 1'b0;
    end else if (at_halt) begin
      halted <= 1'b1;
      rts_n  <= 1'b1;
    end else if (at_resume) begin
      halted <= 1'b0;
      rts_n  <= 1'b0;
    end else begin
      rts_n  <= halted;
    end
  end

  // R3
  halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !cfg_error && fifo_level >= halt_lvl) |=> rts_n);

  // R4
  resume_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !cfg_error && fifo_level <= resume_lvl) |=> !rts_n);

  // R7
  fail_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !rts_n);

  // R8
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n == !$past(sw_req)));

  // R2
  ctl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> (rd_data[3:1] == 3'b000));
endmodule

// File: tb/sim_rx_rts_hysteresis.sv
module sim_rx_rts_hysteresis;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, auto_en, wr_en, addr;
  logic [6:0] level;
  logic [7:0] wr_data;
  wire  [7:0] rd_data;
  wire        rts_n, cfg_error, trig_warn;

  int checks = 0, errors = 0;
  logic [7:0] m_thr, m_ctl;
  logic       m_rts, m_halted;

  rx_rts_hysteresis u0 (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .fifo_level(level),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .rts_n(rts_n), .cfg_error(cfg_error), .trig_warn(trig_warn)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(logic aen);
    return aen && (m_thr[3:0] <= m_thr[7:4]);
  endfunction

  task automatic cyc(logic aen, int lvl, logic we = 1'b0, logic a = 1'b0, logic [7:0] d = 8'h00);
    logic n_rts, n_h;
    string tag;
    int hl, rl;
    @(negedge clk);
    auto_en = aen; level = lvl[6:0]; wr_en = we; addr = a; wr_data = d;
    hl = 4 * m_thr[3:0];
    rl = 4 * m_thr[7:4];
    if (!aen) begin n_rts = !m_ctl[0]; n_h = 1'b0; tag = "R8"; end
    else if (exp_err(aen)) begin n_rts = 1'b0; n_h = 1'b0; tag = "R7"; end
    else if (lvl >= hl) begin n_rts = 1'b1; n_h = 1'b1; tag = (lvl > 60) ? "R10" : "R3"; end
    else if (lvl <= rl) begin n_rts = 1'b0; n_h = 1'b0; tag = "R4"; end
    else begin n_rts = m_halted; n_h = m_halted; tag = "R5"; end
    @(posedge clk);
    m_rts = n_rts; m_halted = n_h;
    if (we) begin
      if (a) m_ctl = {d[7:4], 3'b000, d[0]};
      else   m_thr = d;
    end
    #1;
    chk(tag, {7'd0, rts_n}, {7'd0, m_rts});
    chk("R6", {7'd0, cfg_error}, {7'd0, exp_err(aen)});
    chk("R9", {7'd0, trig_warn}, {7'd0, m_thr[3:0] < m_ctl[7:4]});
    chk("R2", rd_data, a ? m_ctl : m_thr);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lv;
    void'($urandom(32'd2024));
    rst_n = 1'b0; auto_en = 1'b0; level = '0; wr_en = 1'b0; addr = 1'b0; wr_data = '0;
    m_thr = 8'h0F; m_ctl = 8'h00; m_rts = 1'b1; m_halted = 1'b0;
    #11 rst_n = 1'b1;
    #1;
    chk("R1", rd_data, 8'h0F);
    chk("R1", {7'd0, rts_n}, 8'd1);
    chk("R1", {7'd0, cfg_error}, 8'd0);
    chk("R1", {7'd0, trig_warn}, 8'd0);
    addr = 1'b1; #1;
    chk("R1", rd_data, 8'h00);

    cyc(1'b0, 0, 1'b1, 1'b0, 8'h38);
    cyc(1'b0, 0, 1'b1, 1'b1, 8'hFF);
    cyc(1'b0, 0, 1'b0, 1'b1);
    for (int i = 0; i <= 64; i++) cyc(1'b1, i);
    for (int i = 64; i >= 0; i--) cyc(1'b1, i);
    cyc(1'b1, 64);
    cyc(1'b1, 61);
    cyc(1'b1, 20, 1'b1, 1'b0, 8'h22);
    cyc(1'b1, 20);
    cyc(1'b1, 64);
    cyc(1'b1, 64, 1'b1, 1'b0, 8'h2A);
    cyc(1'b1, 50);
    cyc(1'b1, 20);
    cyc(1'b0, 20, 1'b1, 1'b1, 8'h01);
    cyc(1'b0, 20, 1'b1, 1'b1, 8'h00);
    cyc(1'b0, 20);
    cyc(1'b1, 20);
    cyc(1'b1, 0, 1'b1, 1'b1, 8'hB0);

    lv = 30;
    for (int n = 0; n < 4000; n++) begin
      logic aen, we, a;
      logic [7:0] d;
      aen = ($urandom_range(0, 19) != 0);
      we = ($urandom_range(0, 39) == 0);
      a = $urandom_range(0, 1);
      d = $urandom_range(0, 255);
      if (we && !a && $urandom_range(0, 3) != 0) begin
        int h, r;
        h = $urandom_range(1, 15);
        r = $urandom_range(0, h - 1);
        d = {r[3:0], h[3:0]};
      end
      if ($urandom_range(0, 49) == 0) lv = $urandom_range(0, 64);
      else lv = lv + $urandom_range(0, 4) - 2;
      if (lv < 0) lv = 0;
      if (lv > 64) lv = 64;
      cyc(aen, lv, we, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule